// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block is a watchdog timer driven by one 8-bit control register. Software writes the register through a plain write strobe with a data byte, and it reads the register back on a data output. A restart strobe takes the place of the processor's watchdog-restart instruction. The block counts clock cycles since the most recent restart, or since reset. While monitoring is switched on and that count goes beyond the selected timeout, the block requests a system reset.

The register has three fields. A three-bit timeout select sits in bits 2:0. The monitoring enable is bit 3 and a change-unlock bit is bit 4. The timeout is a base cycle count shifted left by the select value. The enable cannot simply be written off. Software must first write the unlock bit as 1, which opens a short window. While the window is open, a later write may clear the enable. The window closes by itself after a set number of cycles. A mask parameter defines which register bits exist. Bits outside the mask are never stored and always read as 0.

Top module: `wdt_protected`

## Requirements
- R1: While reset is held, `rdData` reads 0x00 and `wdtReset` is low; the unlock window count is loaded to its full length.
- R2: A write stores `wrData & IMPL_MASK`, and `rdData` always equals the stored value with unmasked bits at 0. With the default mask 0x1F, writing 0xE2 reads back 0x02 and writing 0xFF with the enable clear reads back 0x1F.
- R3: The timeout is `BASE_CYCLES << sel`, where sel is bits 2:0. With monitoring on, `wdtReset` goes high in the cycle where the number of clock edges since the last restart first exceeds the timeout. It stays low while that number is less than or equal to the timeout.
- R4: A restart strobe sampled at a clock edge sets the elapsed count to zero, so `wdtReset` is low in the following cycle.
- R5: Once raised, `wdtReset` stays high on every cycle until a restart strobe arrives or monitoring is switched off. Disabling drops it in the cycle after the write.
- R6: If the stored enable (bit 3) is 1 and the stored unlock bit (bit 4) is 0 before a write, the write stores bit 3 as 1 whatever `wrData` holds. All other bits take the written value.
- R7: Writing bit 4 as 1 sets the unlock bit and loads the window count with `WINDOW_CYCLES`. Bit 4 reads 1 for `WINDOW_CYCLES` cycles after that write and then clears on its own. A write made while it reads 1 can clear the enable.
- R8: Writing bit 4 as 1 again while the window is open restarts the full window length from that write.
- R9: With the enable at 0, `wdtReset` never asserts. The elapsed count runs from the last restart and not from the enabling write, so enabling after a long idle time with a short timeout requests reset in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| restart | input | 1 | Watchdog restart strobe |
| rdData | output | 8 | Register read data (masked) |
| wdtReset | output | 1 | Reset request, held while overdue |

## Verification
The bench builds the block with `BASE_CYCLES` = 4, `WINDOW_CYCLES` = 4 and the default mask 0x1F. With these values, timeouts run from 4 to 512 cycles. The exact edge where a 16-cycle timeout first trips can be checked, and so can the self-closing and reloaded unlock window. Idle stretches long enough to push the elapsed count past small timeouts before enabling also fit in a short run. The default mask leaves bits 7:5 unimplemented, so the masking of both writes and reads is exercised.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W     = 8;
  localparam int PRESC_W   = 3;
  localparam int PRESC_LSB = 0;
  localparam int EN_BIT    = 3;
  localparam int CE_BIT    = 4;

  typedef struct packed {
    logic               clrElapsed;
    logic               monitorOn;
    logic [PRESC_W-1:0] presc;
  } wdt_strobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK     = 8'h1F,
  parameter int               WINDOW_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             restart,
  output logic [REG_W-1:0] ctrlReg,
  output wdt_strobe_t      strb
);
  localparam int WIN_W = $clog2(WINDOW_CYCLES + 1);

  logic [REG_W-1:0] guardedVal;
  logic [REG_W-1:0] maskedVal;
  logic [WIN_W-1:0] winCnt;
  logic             ceLoad;
  logic             winRun;
  logic             winExpire;

  // Protection is judged on the stored value, never on the incoming byte.
  always_comb begin
    guardedVal = wrData;
    if (ctrlReg[EN_BIT] && !ctrlReg[CE_BIT]) begin
      guardedVal[EN_BIT] = 1'b1;
    end
    maskedVal = guardedVal & IMPL_MASK;
  end

  assign ceLoad    = wrEn && maskedVal[CE_BIT];
  assign winRun    = !wrEn && ctrlReg[CE_BIT];
  assign winExpire = winRun && (winCnt <= WIN_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (wrEn) begin
      ctrlReg <= maskedVal;
    end else if (winExpire) begin
      ctrlReg[CE_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= WIN_W'(WINDOW_CYCLES);
    end else if (ceLoad) begin
      winCnt <= WIN_W'(WINDOW_CYCLES);
    end else if (winRun && !winExpire) begin
      winCnt <= winCnt - WIN_W'(1);
    end
  end

  always_comb begin
    strb.clrElapsed = restart;
    strb.monitorOn  = ctrlReg[EN_BIT];
    strb.presc      = ctrlReg[PRESC_LSB +: PRESC_W];
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  wdt_strobe_t strb,
  output logic        overdue
);
  localparam int SEL_N       = 2 ** PRESC_W;
  localparam int MAX_TIMEOUT = BASE_CYCLES * (2 ** (SEL_N - 1));
  localparam int CNT_W       = $clog2(MAX_TIMEOUT + 2);

  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] timeoutTab [SEL_N];
  logic [CNT_W-1:0] timeoutSel;

  for (genvar g = 0; g < SEL_N; g++) begin : g_tab
    assign timeoutTab[g] = CNT_W'(BASE_CYCLES * (2 ** g));
  end

  assign timeoutSel = timeoutTab[strb.presc];

  // Saturating count of edges since the last restart; the ceiling lies
  // above every selectable timeout, so saturation never hides an expiry.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elapsed <= '0;
    end else if (strb.clrElapsed) begin
      elapsed <= '0;
    end else if (elapsed != '1) begin
      elapsed <= elapsed + CNT_W'(1);
    end
  end

  assign overdue = strb.monitorOn && (elapsed > timeoutSel);
endmodule

// File: rtl/wdt_protected.sv
module wdt_protected
  import wdt_pkg::*;
#(
  parameter int               BASE_CYCLES   = 16,
  parameter int               WINDOW_CYCLES = 4,
  parameter logic [REG_W-1:0] IMPL_MASK     = 8'h1F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             restart,
  output logic [REG_W-1:0] rdData,
  output logic             wdtReset
);
  logic [REG_W-1:0] ctrlReg;
  wdt_strobe_t      strb;

  wdt_ctrl #(
    .IMPL_MASK    (IMPL_MASK),
    .WINDOW_CYCLES(WINDOW_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .restart(restart),
    .ctrlReg(ctrlReg),
    .strb   (strb)
  );

  wdt_datapath #(
    .BASE_CYCLES(BASE_CYCLES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .overdue(wdtReset)
  );

  assign rdData = ctrlReg & IMPL_MASK;
endmodule

// File: rtl/wdt_protected_chk.sv
module wdt_protected_chk
  import wdt_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK = 8'h1F
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             restart,
  input logic [REG_W-1:0] rdData,
  input logic             wdtReset
);
  p_unmasked_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~IMPL_MASK) == '0);

  p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !wdtReset);

  p_request_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wdtReset && !restart && !wrEn) |=> wdtReset);

  p_enable_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdData[EN_BIT] && !rdData[CE_BIT]) |=> rdData[EN_BIT]);

  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[EN_BIT] |-> !wdtReset);
endmodule

bind wdt_protected wdt_protected_chk #(.IMPL_MASK(IMPL_MASK)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .restart (restart),
  .rdData  (rdData),
  .wdtReset(wdtReset)
);

// File: tb/wdt_protected_tb.sv
module wdt_protected_tb;
  localparam int         BASE = 4;
  localparam int         WIN  = 4;
  localparam logic [7:0] MASK = 8'h1F;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       restart = 1'b0;
  logic [7:0] rdData;
  logic       wdtReset;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wdt_protected #(
    .BASE_CYCLES  (BASE),
    .WINDOW_CYCLES(WIN),
    .IMPL_MASK    (MASK)
  ) u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .restart (restart),
    .rdData  (rdData),
    .wdtReset(wdtReset)
  );

  // Behavioural reference model
  logic [7:0] mReg = 8'h00;
  int         mWin = WIN;
  longint     mElapsed = 0;

  always @(posedge clk) begin
    logic [7:0] old;
    logic [7:0] v;
    if (!rstN) begin
      mReg = 8'h00;
      mWin = WIN;
      mElapsed = 0;
    end else begin
      old = mReg;
      if (restart) mElapsed = 0;
      else mElapsed = mElapsed + 1;
      if (wrEn) begin
        v = wrData;
        if (old[3] && !old[4]) v[3] = 1'b1;
        v = v & MASK;
        if (v[4]) mWin = WIN;
        mReg = v;
      end else if (old[4]) begin
        if (mWin <= 1) mReg[4] = 1'b0;
        else mWin = mWin - 1;
      end
    end
  end

  function automatic logic expReq();
    longint t;
    t = longint'(BASE) << mReg[2:0];
    return mReg[3] && (mElapsed > t);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2 rdData vs model", 32'(rdData), 32'(mReg));
      chk("R3 wdtReset vs model", 32'(wdtReset), 32'(expReq()));
    end
  end

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic kick();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rdData", 32'(rdData), 32'h00);
    chk("R1 reset wdtReset", 32'(wdtReset), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    wr(8'hE2);
    chk("R2 masked write", 32'(rdData), 32'h02);

    repeat (20) @(negedge clk);
    chk("R9 disabled no request", 32'(wdtReset), 32'h0);

    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    wrEn = 1'b1;
    wrData = 8'h0A;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (15) @(negedge clk);
    chk("R3 at timeout low", 32'(wdtReset), 32'h0);
    @(negedge clk);
    chk("R3 past timeout high", 32'(wdtReset), 32'h1);
    repeat (5) @(negedge clk);
    chk("R5 request held", 32'(wdtReset), 32'h1);
    kick();
    chk("R4 restart clears", 32'(wdtReset), 32'h0);

    wr(8'h00);
    chk("R6 enable forced", 32'(rdData), 32'h08);

    wr(8'h18);
    repeat (3) @(negedge clk);
    chk("R7 window still open", 32'(rdData), 32'h18);
    @(negedge clk);
    chk("R7 window closed", 32'(rdData), 32'h08);
    wr(8'h18);
    wr(8'h00);
    chk("R7 disable in window", 32'(rdData), 32'h00);
    chk("R5 disable drops request", 32'(wdtReset), 32'h0);

    wr(8'h10);
    repeat (2) @(negedge clk);
    wr(8'h10);
    repeat (3) @(negedge clk);
    chk("R8 reloaded window open", 32'(rdData), 32'h10);
    @(negedge clk);
    chk("R8 reloaded window closed", 32'(rdData), 32'h00);

    repeat (30) @(negedge clk);
    wr(8'h08);
    chk("R9 late enable trips at once", 32'(wdtReset), 32'h1);
    wr(8'h18);
    wr(8'h00);
    chk("R5 request off after disable", 32'(wdtReset), 32'h0);

    wr(8'hFF);
    chk("R2 full write masked", 32'(rdData), 32'h1F);
    repeat (8) @(negedge clk);
    finish_run();
  end
endmodule